// File: doc/BRIEF.md
# Channel-Banked DMA Control Register File

This block is the software-visible control store of a multi-channel DMA engine. A 32-bit slave bus with separate read and write strobes reaches a small set of global registers and two banked windows. Writing a channel number to a select register points the channel window at one channel's control, descriptor base, descriptor count, interrupt status and interrupt enable registers. A second select register does the same for per-port control. Each channel then drives its enable, direction, weight, descriptor base and count, and its own interrupt line into the datapath.

The datapath reports events on a six-bit strobe vector per channel. Software clears pending events by writing ones, and unmasks them twice: once per status bit inside the channel and once per channel in a global enable word. A channel reset is requested by writing its reset bit. The bit then reads back as one for a fixed number of cycles and clears itself, so software can poll for completion.

Top module: `chan_bank_regs`

## Requirements
- R1: A read of offset 0x08 returns a constant: the channel count in bits 31:20, the port count in bits 19:16 and the revision parameter in bits 4:0, with the other bits zero (0x01440003 with default parameters).
- R2: Offset 0x18 holds the channel select in bits 7:0. Offsets 0x1C, 0x20, 0x24, 0x28 and 0x2C read and write only the selected channel, and every channel keeps its own descriptor base (0x20, 32 bits) and descriptor count (0x24, DLEN_W bits), which appear on its output slices.
- R3: Channel control at 0x1C has enable in bit 0, reset in bit 1, transmit direction in bit 8 (one means transmit) and weight in bits 17:16; the enable, direction and weight fields drive that channel's outputs.
- R4: Writing a one to bit 1 of 0x1C starts a channel reset. Back-to-back reads of 0x1C that begin in the next cycle return bit 1 as one exactly RST_CYC times and then zero. The write forces the channel's enable to zero and clears its status bits.
- R5: Channel status at 0x28 occupies bits 6:1. Event input bit i of a channel sets status bit i+1, and bit 3 is descriptor complete. Writing ones clears the matching bits (0x7E clears all of them), and an event in the same cycle as a clearing write leaves its bit set.
- R6: A channel's interrupt output is high only when its bit in the global enable word at 0xF4 (bit n for channel n) is set and a status bit is set whose bit in the channel's enable register at 0x2C (bits 6:1) is also set.
- R7: While the channel select is NUM_CH or higher, reads of 0x1C to 0x2C return zero and writes to them change no channel.
- R8: Offset 0x40 selects a port (bits 3:0). Port control at 0x44 has packet drop in bit 6 and swap select in bits 11:8, drives the selected port's outputs, and reads zero and ignores writes when the select is NUM_PORT or higher.
- R9: Offset 0x10 bit 0 is the engine reset request output, and offset 0x14 keeps only poll enable in bit 31 and divider select in bit 6, both driven as outputs.
- R10: Read data appears in the cycle after a read strobe and is zero when no read was strobed or the offset is unmapped (including unaligned offsets).
- R11: After reset every register reads zero except the ID, and all enable and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ch_evt | input | 6*NUM_CH | Per-channel event strobes, six bits per channel |
| ch_on | output | NUM_CH | Channel enable |
| ch_tx | output | NUM_CH | Channel direction, one for transmit |
| ch_weight | output | 2*NUM_CH | Channel weight |
| ch_base | output | 32*NUM_CH | Descriptor base per channel |
| ch_len | output | DLEN_W*NUM_CH | Descriptor count per channel |
| ch_irq | output | NUM_CH | Per-channel interrupt |
| eng_rst | output | 1 | Engine reset request |
| poll_en | output | 1 | Descriptor polling enable |
| poll_div | output | 1 | Polling divider select |
| port_drop | output | NUM_PORT | Packet drop enable per port |
| port_swap | output | 4*NUM_PORT | Swap select per port |

## Verification
Descriptor bases and counts are written to two channels in turn and read back under each selection, which separates a true per-channel bank from a shared register or a select that is ignored. Status is driven with a lone descriptor-complete event, with two events pending and one cleared, and with an event colliding with a clearing write. These cases separate write-one-to-clear from plain writes, set priority from clear priority, and the two enable levels from each other. The reset bit is polled cycle by cycle to pin down its exact length. Selects just beyond the last channel and port show that out-of-range windows neither read nor write anything.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    localparam logic [7:0] A_ID    = 8'h08;
    localparam logic [7:0] A_GCTL  = 8'h10;
    localparam logic [7:0] A_POLL  = 8'h14;
    localparam logic [7:0] A_CSEL  = 8'h18;
    localparam logic [7:0] A_CCTL  = 8'h1C;
    localparam logic [7:0] A_CBASE = 8'h20;
    localparam logic [7:0] A_CLEN  = 8'h24;
    localparam logic [7:0] A_CSTAT = 8'h28;
    localparam logic [7:0] A_CIEN  = 8'h2C;
    localparam logic [7:0] A_PSEL  = 8'h40;
    localparam logic [7:0] A_PCTL  = 8'h44;
    localparam logic [7:0] A_GIEN  = 8'hF4;

    localparam int STAT_W = 6;

    // write strobes into one channel's bank
    typedef struct packed {
        logic ctl;
        logic base;
        logic len;
        logic stat;
        logic ien;
    } chan_wr_t;
endpackage

// File: rtl/chan_slot.sv
module chan_slot
    import dmareg_pkg::*;
#(
    parameter int DLEN_W  = 16,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_wr_t          wr,
    input  logic [31:0]       wdata,
    input  logic [STAT_W-1:0] evt,
    output logic              on,
    output logic              tx,
    output logic [1:0]        weight,
    output logic              busy,
    output logic [31:0]       base,
    output logic [DLEN_W-1:0] len,
    output logic [STAT_W-1:0] stat,
    output logic [STAT_W-1:0] ien,
    output logic              pend
);
    localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYC - 1);

    typedef struct packed {
        logic              on;
        logic              tx;
        logic [1:0]        weight;
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [31:0]       base;
        logic [DLEN_W-1:0] len;
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] ien;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // running reset countdown
        if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end
        if (wr.ctl) begin
            s_d.on     = wdata[0];
            s_d.tx     = wdata[8];
            s_d.weight = wdata[17:16];
            if (wdata[1]) begin
                s_d.busy = 1'b1;
                s_d.cnt  = CNT_LOAD;
            end
        end
        if (wr.base) s_d.base = wdata;
        if (wr.len)  s_d.len  = wdata[DLEN_W-1:0];
        if (wr.ien)  s_d.ien  = wdata[STAT_W:1];
        // clear by ones, then events win
        s_d.stat = s_q.stat & ~(wr.stat ? wdata[STAT_W:1] : '0);
        s_d.stat = s_d.stat | evt;
        if (s_d.busy) begin
            s_d.on   = 1'b0;
            s_d.stat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign on     = s_q.on;
    assign tx     = s_q.tx;
    assign weight = s_q.weight;
    assign busy   = s_q.busy;
    assign base   = s_q.base;
    assign len    = s_q.len;
    assign stat   = s_q.stat;
    assign ien    = s_q.ien;
    assign pend   = |(s_q.stat & s_q.ien);
endmodule

// File: rtl/port_slot.sv
module port_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [5:0] wfield,   // write data bits 11:6
    output logic       drop,
    output logic [3:0] swap
);
    typedef struct packed {
        logic       drop;
        logic [3:0] swap;
    } pslot_t;

    pslot_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr) begin
            p_d.drop = wfield[0];
            p_d.swap = wfield[5:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign drop = p_q.drop;
    assign swap = p_q.swap;
endmodule

// File: rtl/chan_bank_regs.sv
module chan_bank_regs
    import dmareg_pkg::*;
#(
    parameter int         NUM_CH   = 20,
    parameter int         NUM_PORT = 4,
    parameter int         DLEN_W   = 16,
    parameter int         RST_CYC  = 4,
    parameter logic [4:0] HW_REV   = 5'd3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [31:0]                bus_rdata,
    input  logic [STAT_W*NUM_CH-1:0]   ch_evt,
    output logic [NUM_CH-1:0]          ch_on,
    output logic [NUM_CH-1:0]          ch_tx,
    output logic [2*NUM_CH-1:0]        ch_weight,
    output logic [32*NUM_CH-1:0]       ch_base,
    output logic [DLEN_W*NUM_CH-1:0]   ch_len,
    output logic [NUM_CH-1:0]          ch_irq,
    output logic                       eng_rst,
    output logic                       poll_en,
    output logic                       poll_div,
    output logic [NUM_PORT-1:0]        port_drop,
    output logic [4*NUM_PORT-1:0]      port_swap
);
    localparam int CSEL_W = 8;
    localparam int PSEL_W = 4;
    localparam logic [31:0] ID_WORD =
        {12'(NUM_CH), 4'(NUM_PORT), 11'd0, HW_REV};

    typedef struct packed {
        logic              gctl;
        logic              poll_en;
        logic              poll_div;
        logic [CSEL_W-1:0] csel;
        logic [PSEL_W-1:0] psel;
        logic [NUM_CH-1:0] gien;
        logic [31:0]       rdata;
    } glob_t;

    glob_t g_d, g_q;

    chan_wr_t                 cwr      [NUM_CH];
    logic [NUM_PORT-1:0]      pwr;
    logic [31:0]              ctl_word [NUM_CH];
    logic [31:0]              base_w   [NUM_CH];
    logic [DLEN_W-1:0]        len_w    [NUM_CH];
    logic [STAT_W-1:0]        stat_w   [NUM_CH];
    logic [STAT_W-1:0]        ien_w    [NUM_CH];
    logic [NUM_CH-1:0]        pend;
    logic [NUM_CH-1:0]        busy;
    logic [STAT_W*NUM_CH-1:0] stat_all;
    logic [NUM_CH-1:0]        gien_cur;
    logic [CSEL_W-1:0]        csel_cur;

    // per-channel banks
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic hit;
        assign hit = bus_wr && (g_q.csel == CSEL_W'(n));
        assign cwr[n].ctl  = hit && (bus_addr == A_CCTL);
        assign cwr[n].base = hit && (bus_addr == A_CBASE);
        assign cwr[n].len  = hit && (bus_addr == A_CLEN);
        assign cwr[n].stat = hit && (bus_addr == A_CSTAT);
        assign cwr[n].ien  = hit && (bus_addr == A_CIEN);

        chan_slot #(.DLEN_W(DLEN_W), .RST_CYC(RST_CYC)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (cwr[n]),
            .wdata  (bus_wdata),
            .evt    (ch_evt[STAT_W*n +: STAT_W]),
            .on     (ch_on[n]),
            .tx     (ch_tx[n]),
            .weight (ch_weight[2*n +: 2]),
            .busy   (busy[n]),
            .base   (base_w[n]),
            .len    (len_w[n]),
            .stat   (stat_w[n]),
            .ien    (ien_w[n]),
            .pend   (pend[n])
        );

        assign ctl_word[n] = {14'd0, ch_weight[2*n +: 2], 7'd0, ch_tx[n],
                              6'd0, busy[n], ch_on[n]};
        assign ch_base[32*n +: 32]        = base_w[n];
        assign ch_len[DLEN_W*n +: DLEN_W] = len_w[n];
        assign stat_all[STAT_W*n +: STAT_W] = stat_w[n];
        assign ch_irq[n] = g_q.gien[n] & pend[n];
    end

    // per-port banks
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        assign pwr[p] = bus_wr && (bus_addr == A_PCTL) &&
                        (g_q.psel == PSEL_W'(p));
        port_slot u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (pwr[p]),
            .wfield (bus_wdata[11:6]),
            .drop   (port_drop[p]),
            .swap   (port_swap[4*p +: 4])
        );
    end

    logic [31:0] ch_rd, port_rd, rd_word;

    always_comb begin
        ch_rd = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (g_q.csel == CSEL_W'(n)) begin
                unique case (bus_addr)
                    A_CCTL:  ch_rd = ctl_word[n];
                    A_CBASE: ch_rd = base_w[n];
                    A_CLEN:  ch_rd = 32'(len_w[n]);
                    A_CSTAT: ch_rd = {25'd0, stat_w[n], 1'b0};
                    A_CIEN:  ch_rd = {25'd0, ien_w[n], 1'b0};
                    default: ch_rd = '0;
                endcase
            end
        end
        port_rd = '0;
        for (int p = 0; p < NUM_PORT; p++) begin
            if (g_q.psel == PSEL_W'(p))
                port_rd = {20'd0, port_swap[4*p +: 4], 1'b0, port_drop[p], 6'd0};
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_ID:    rd_word = ID_WORD;
            A_GCTL:  rd_word = {31'd0, g_q.gctl};
            A_POLL:  rd_word = {g_q.poll_en, 24'd0, g_q.poll_div, 6'd0};
            A_CSEL:  rd_word = 32'(g_q.csel);
            A_CCTL, A_CBASE, A_CLEN, A_CSTAT, A_CIEN:
                     rd_word = ch_rd;
            A_PSEL:  rd_word = 32'(g_q.psel);
            A_PCTL:  rd_word = port_rd;
            A_GIEN:  rd_word = 32'(g_q.gien);
            default: rd_word = '0;
        endcase
    end

    always_comb begin
        g_d = g_q;
        if (bus_wr) begin
            unique case (bus_addr)
                A_GCTL: g_d.gctl = bus_wdata[0];
                A_POLL: begin
                    g_d.poll_en  = bus_wdata[31];
                    g_d.poll_div = bus_wdata[6];
                end
                A_CSEL: g_d.csel = bus_wdata[CSEL_W-1:0];
                A_PSEL: g_d.psel = bus_wdata[PSEL_W-1:0];
                A_GIEN: g_d.gien = bus_wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
        g_d.rdata = bus_rd ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign bus_rdata = g_q.rdata;
    assign eng_rst   = g_q.gctl;
    assign poll_en   = g_q.poll_en;
    assign poll_div  = g_q.poll_div;
    assign gien_cur  = g_q.gien;
    assign csel_cur  = g_q.csel;
endmodule

// File: rtl/chan_bank_regs_chk.sv
module chan_bank_regs_chk
    import dmareg_pkg::*;
#(
    parameter int         NUM_CH   = 20,
    parameter int         NUM_PORT = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [7:0]               bus_addr,
    input logic [31:0]              bus_wdata,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [31:0]              bus_rdata,
    input logic [STAT_W*NUM_CH-1:0] ch_evt,
    input logic [STAT_W*NUM_CH-1:0] stat_all,
    input logic [NUM_CH-1:0]        ch_on,
    input logic [NUM_CH-1:0]        ch_irq,
    input logic [NUM_CH-1:0]        gien_cur,
    input logic [7:0]               csel_cur
);
    logic ch_window;
    assign ch_window = (bus_addr == A_CCTL) || (bus_addr == A_CBASE) ||
                       (bus_addr == A_CLEN) || (bus_addr == A_CSTAT) ||
                       (bus_addr == A_CIEN);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'd0);

    a_r7_nosel_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ch_window && (int'(csel_cur) >= NUM_CH)) |=> bus_rdata == 32'd0);

    a_r1_id_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ID) |=>
            (bus_rdata[31:20] == 12'(NUM_CH)) && (bus_rdata[19:16] == 4'(NUM_PORT)));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        a_r6_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !gien_cur[n] |-> !ch_irq[n]);

        a_r4_reset_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_CCTL && bus_wdata[1] && csel_cur == 8'(n))
                |=> !ch_on[n]);

        a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_CSTAT && csel_cur == 8'(n) &&
             bus_wdata[6:1] == 6'h3F && ch_evt[STAT_W*n +: STAT_W] == '0)
                |=> stat_all[STAT_W*n +: STAT_W] == '0);
    end
endmodule

bind chan_bank_regs chan_bank_regs_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_PORT (NUM_PORT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ch_evt    (ch_evt),
    .stat_all  (stat_all),
    .ch_on     (ch_on),
    .ch_irq    (ch_irq),
    .gien_cur  (gien_cur),
    .csel_cur  (csel_cur)
);

// File: tb/tb_chan_bank_regs.sv
`timescale 1ns/1ps
module tb_chan_bank_regs;
    localparam int NCH = 20;
    localparam int NPT = 4;
    localparam int DLW = 16;
    localparam int RSTC = 4;

    localparam logic [7:0] O_ID = 8'h08, O_GCTL = 8'h10, O_POLL = 8'h14,
        O_CSEL = 8'h18, O_CCTL = 8'h1C, O_CBASE = 8'h20, O_CLEN = 8'h24,
        O_CSTAT = 8'h28, O_CIEN = 8'h2C, O_PSEL = 8'h40, O_PCTL = 8'h44,
        O_GIEN = 8'hF4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, rd_chk = 1'b0;
    logic [31:0] bus_rdata;
    logic [6*NCH-1:0] ch_evt = '0;
    logic [NCH-1:0] ch_on, ch_tx, ch_irq;
    logic [2*NCH-1:0] ch_weight;
    logic [32*NCH-1:0] ch_base;
    logic [DLW*NCH-1:0] ch_len;
    logic eng_rst, poll_en, poll_div;
    logic [NPT-1:0] port_drop;
    logic [4*NPT-1:0] port_swap;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chan_bank_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ch_evt(ch_evt),
        .ch_on(ch_on), .ch_tx(ch_tx), .ch_weight(ch_weight), .ch_base(ch_base),
        .ch_len(ch_len), .ch_irq(ch_irq), .eng_rst(eng_rst), .poll_en(poll_en),
        .poll_div(poll_div), .port_drop(port_drop), .port_swap(port_swap)
    );

    // scoreboard queues
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        chk_seen = 1'b0;

    always @(posedge clk) chk_seen <= bus_rd && rd_chk;

    always @(negedge clk) begin
        if (chk_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic check(input bit ok, input string t, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1; rd_chk = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; rd_chk = 1'b0;
    endtask

    task automatic rd_raw(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_evt(input int ch, input int bitn);
        ch_evt[6*ch + bitn] = 1'b1;
        @(negedge clk);
        ch_evt = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int polls;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check(ch_on == '0 && ch_irq == '0, "R11 outputs idle", 32'(ch_on), 0);
        check(eng_rst == 0 && poll_en == 0, "R11 globals", {eng_rst, poll_en}, 0);
        rd_exp(O_CSEL, 0, "R11 select");
        rd_exp(O_CCTL, 0, "R11 ch0 control");
        rd_exp(O_GIEN, 0, "R11 global enable");

        // R1 ID
        rd_exp(O_ID, 32'h0144_0003, "R1 id word");

        // R2 banked descriptor registers
        wr(O_CSEL, 5);
        wr(O_CBASE, 32'hA000_1000);
        wr(O_CLEN, 32'h40);
        wr(O_CSEL, 7);
        wr(O_CBASE, 32'hB000_2000);
        wr(O_CLEN, 32'h22);
        rd_exp(O_CBASE, 32'hB000_2000, "R2 ch7 base");
        wr(O_CSEL, 5);
        rd_exp(O_CBASE, 32'hA000_1000, "R2 ch5 base");
        rd_exp(O_CLEN, 32'h40, "R2 ch5 count");
        check(ch_base[32*5 +: 32] == 32'hA000_1000, "R2 ch5 base out",
              ch_base[32*5 +: 32], 32'hA000_1000);
        check(ch_len[DLW*7 +: DLW] == 16'h22, "R2 ch7 count out",
              32'(ch_len[DLW*7 +: DLW]), 32'h22);

        // R3 control fields
        wr(O_CCTL, 32'h0003_0101);
        check(ch_on[5] && ch_tx[5] && ch_weight[11:10] == 2'd3, "R3 ch5 outputs",
              {ch_on[5], ch_tx[5], ch_weight[11:10]}, 32'hF);
        check(!ch_on[7], "R3 ch7 untouched", 32'(ch_on[7]), 0);
        rd_exp(O_CCTL, 32'h0003_0101, "R3 control readback");

        // R5/R6 status and interrupts
        pulse_evt(5, 2);
        rd_exp(O_CSTAT, 32'h08, "R5 descriptor complete");
        wr(O_CIEN, 32'h08);
        check(!ch_irq[5], "R6 global mask off", 32'(ch_irq[5]), 0);
        wr(O_GIEN, 32'h20);
        check(ch_irq[5], "R6 irq raised", 32'(ch_irq[5]), 1);
        pulse_evt(5, 1);
        rd_exp(O_CSTAT, 32'h0C, "R5 two pending");
        wr(O_CSTAT, 32'h08);
        rd_exp(O_CSTAT, 32'h04, "R5 clear one bit");
        check(!ch_irq[5], "R6 masked status bit", 32'(ch_irq[5]), 0);
        wr(O_CSTAT, 32'h7E);
        rd_exp(O_CSTAT, 32'h00, "R5 clear all");
        // event colliding with a clearing write
        ch_evt[6*5 + 2] = 1'b1;
        wr(O_CSTAT, 32'h7E);
        ch_evt = '0;
        rd_exp(O_CSTAT, 32'h08, "R5 set beats clear");

        // R4 channel reset
        check(ch_irq[5], "R4 irq before reset", 32'(ch_irq[5]), 1);
        wr(O_CCTL, 32'h0003_0103);
        polls = 0;
        for (int i = 0; i < 20; i++) begin
            rd_raw(O_CCTL, d);
            if (!d[1]) break;
            polls++;
        end
        check(polls == RSTC, "R4 reset length", polls, RSTC);
        check(!ch_on[5], "R4 enable forced low", 32'(ch_on[5]), 0);
        rd_exp(O_CCTL, 32'h0003_0100, "R4 control after reset");
        rd_exp(O_CSTAT, 32'h00, "R4 status cleared");
        check(!ch_irq[5], "R4 irq cleared", 32'(ch_irq[5]), 0);

        // R7 out-of-range select
        wr(O_CSEL, NCH);
        rd_exp(O_CBASE, 32'h0, "R7 read none");
        wr(O_CBASE, 32'h0000_DEAD);
        wr(O_CCTL, 32'h1);
        check(ch_on == '0, "R7 write ignored", 32'(ch_on), 0);
        wr(O_CSEL, 0);
        rd_exp(O_CBASE, 32'h0, "R7 ch0 base unchanged");
        wr(O_CSEL, NCH - 1);
        rd_exp(O_CBASE, 32'h0, "R7 last channel base unchanged");

        // R8 ports
        wr(O_PSEL, 1);
        wr(O_PCTL, 32'h0F40);
        check(port_drop == 4'b0010 && port_swap[7:4] == 4'hF, "R8 port1 outputs",
              {port_drop, port_swap}, 32'h2_00F0);
        rd_exp(O_PCTL, 32'h0F40, "R8 port1 readback");
        wr(O_PSEL, 0);
        rd_exp(O_PCTL, 32'h0, "R8 port0 untouched");
        wr(O_PSEL, NPT);
        rd_exp(O_PCTL, 32'h0, "R8 out of range read");
        wr(O_PCTL, 32'h0040);
        check(port_drop == 4'b0010, "R8 out of range write", 32'(port_drop), 2);

        // R9 globals
        wr(O_GCTL, 1);
        check(eng_rst, "R9 engine reset", 32'(eng_rst), 1);
        rd_exp(O_GCTL, 1, "R9 control readback");
        wr(O_POLL, 32'hFFFF_FFFF);
        check(poll_en && poll_div, "R9 poll outputs", {poll_en, poll_div}, 3);
        rd_exp(O_POLL, 32'h8000_0040, "R9 poll fields only");

        // R10 unmapped and idle
        rd_exp(8'h30, 0, "R10 unmapped");
        rd_exp(8'h1D, 0, "R10 unaligned");
        @(negedge clk);
        check(bus_rdata == 0, "R10 idle data", bus_rdata, 0);

        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule